// File: doc/BRIEF.md
# Real-Time Clock Alarm with Repeat Masks

This block is the alarm half of a BCD real-time clock. Software loads four alarm registers (seconds, minutes, hours, day of month) through a byte-wide write port. The running time arrives from an external timekeeping counter as BCD fields, together with a strobe that marks each new second. On every strobe the block compares the time against the stored alarm. When the fields that take part in the comparison all match, it raises its interrupt output for exactly one clock cycle.

Bit 7 of each alarm register is a "don't care" flag for that field. Together the four flags choose the repeat period: once a month, once a day, once an hour, once a minute or every second. Writes to the seconds, minutes and hours registers are range-checked after BCD decoding. A value that is out of range is dropped, and the register keeps its previous value.

Top module: `rtc_alarm_unit`

## Requirements
- R1: `wr_addr` selects the alarm register: 0 is seconds, 1 is minutes, 2 is hours, 3 is day of month. An accepted write stores the whole byte. Bit 7 is that field's mask flag, and the low bits are the BCD value.
- R2: For a seconds or minutes write, the value is decoded from bits 6:0 as tens (bits 6:4) times 10 plus units (bits 3:0). The write is accepted only if this decoded value is 59 or less. Otherwise the register keeps its old contents.
- R3: For an hours write, the value is decoded from bits 5:0 as tens (bits 5:4) times 10 plus units (bits 3:0). The write is accepted only if this decoded value is 23 or less. Otherwise the register keeps its old contents.
- R4: A day-of-month write is always stored. Its comparison value is bits 5:0.
- R5: With all four mask flags clear, the alarm fires only when the day, hour, minute and second all equal the stored values.
- R6: With only the day flag set, the alarm fires whenever the hour, minute and second match, whatever the day.
- R7: With the day and hour flags set and the others clear, the alarm fires whenever the minute and second match.
- R8: With the day, hour and minute flags set and the seconds flag clear, the alarm fires whenever the second matches.
- R9: With all four flags set, the alarm fires on every second strobe.
- R10: Any other flag pattern, such as only the seconds flag set, also fires on every second strobe.
- R11: A comparison happens only in a cycle with `sec_tick` high. `alarm_irq` is high for exactly the one cycle after a qualifying strobe, and it never rises without a strobe.
- R12: Synchronous reset clears all alarm registers to zero and drives `alarm_irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Alarm register select |
| wr_data | input | 8 | Write byte: mask flag in bit 7, BCD value below it |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 6 | Current hours, BCD |
| now_day | input | 6 | Current day of month, BCD |
| sec_tick | input | 1 | One-cycle strobe at each new second |
| alarm_irq | output | 1 | One-cycle interrupt pulse |

## Verification
The checker watches, on every cycle, that the interrupt never rises without a strobe and that rejected seconds and hours writes leave their registers unchanged. It also checks that day writes always land, that the all-masked setting fires on each strobe, and that in monthly mode a seconds mismatch never fires. The scenario tasks are the only place that shows each repeat period in use. They check that a field outside the active comparison set is truly ignored, that a field inside it blocks a firing on mismatch, and that the pulse drops after one cycle.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  localparam int SEC_W  = 7;
  localparam int MIN_W  = 7;
  localparam int HOUR_W = 6;
  localparam int DAY_W  = 6;

  localparam int FLD_SEC  = 0;
  localparam int FLD_MIN  = 1;
  localparam int FLD_HOUR = 2;
  localparam int FLD_DAY  = 3;

  typedef enum logic [2:0] {
    RPT_MONTH,
    RPT_DAY,
    RPT_HOUR,
    RPT_MINUTE,
    RPT_SECOND
  } rpt_mode_e;

  // Two-digit BCD decode: tens * 10 + units (units may exceed 9)
  function automatic logic [6:0] bcd_decode(input logic [6:0] b);
    logic [7:0] t;
    t = ({5'd0, b[6:4]} * 8'd10) + {4'd0, b[3:0]};
    return t[6:0];
  endfunction

endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
  import rtc_alarm_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2,
  parameter int N_FIELDS = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [N_FIELDS*DATA_W-1:0] alm_flat
);

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
    localparam int VAL_BITS = (i == FLD_SEC || i == FLD_MIN) ? 7 : 6;
    localparam int LIMIT    = (i == FLD_SEC || i == FLD_MIN) ? 59 :
                              (i == FLD_HOUR) ? 23 : 127;
    localparam logic [6:0] VAL_MASK = 7'((1 << VAL_BITS) - 1);

    logic [DATA_W-1:0] q;
    logic [6:0]        decoded;
    logic              in_range;

    always_comb begin
      decoded  = bcd_decode(wr_data[6:0] & VAL_MASK);
      in_range = (int'(decoded) <= LIMIT);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (wr_en && (wr_addr == ADDR_W'(i)) && in_range) begin
        q <= wr_data;
      end
    end

    assign alm_flat[i*DATA_W +: DATA_W] = q;
  end

endmodule

// File: rtl/alarm_mode_decode.sv
module alarm_mode_decode
  import rtc_alarm_pkg::*;
#(
  parameter int N_FIELDS = 4
) (
  input  logic [N_FIELDS-1:0] mask_bits,   // index by field: sec, min, hour, day
  output rpt_mode_e           mode,
  output logic [N_FIELDS-1:0] cmp_en
);

  always_comb begin
    unique case ({mask_bits[FLD_DAY], mask_bits[FLD_HOUR],
                  mask_bits[FLD_MIN], mask_bits[FLD_SEC]})
      4'b0000: mode = RPT_MONTH;
      4'b1000: mode = RPT_DAY;
      4'b1100: mode = RPT_HOUR;
      4'b1110: mode = RPT_MINUTE;
      default: mode = RPT_SECOND;
    endcase
  end

  always_comb begin
    cmp_en           = '0;
    cmp_en[FLD_SEC]  = (mode != RPT_SECOND);
    cmp_en[FLD_MIN]  = (mode == RPT_MONTH) || (mode == RPT_DAY) || (mode == RPT_HOUR);
    cmp_en[FLD_HOUR] = (mode == RPT_MONTH) || (mode == RPT_DAY);
    cmp_en[FLD_DAY]  = (mode == RPT_MONTH);
  end

endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import rtc_alarm_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int N_FIELDS = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_FIELDS*DATA_W-1:0] alm_flat,
  input  logic [N_FIELDS-1:0]        cmp_en,
  input  logic [SEC_W-1:0]           now_sec,
  input  logic [MIN_W-1:0]           now_min,
  input  logic [HOUR_W-1:0]          now_hour,
  input  logic [DAY_W-1:0]           now_day,
  input  logic                       sec_tick,
  output logic                       irq
);

  logic [N_FIELDS-1:0] field_eq;
  logic                hit;

  always_comb begin
    field_eq           = '1;
    field_eq[FLD_SEC]  = alm_flat[FLD_SEC*DATA_W  +: SEC_W]  == now_sec;
    field_eq[FLD_MIN]  = alm_flat[FLD_MIN*DATA_W  +: MIN_W]  == now_min;
    field_eq[FLD_HOUR] = alm_flat[FLD_HOUR*DATA_W +: HOUR_W] == now_hour;
    field_eq[FLD_DAY]  = alm_flat[FLD_DAY*DATA_W  +: DAY_W]  == now_day;
    hit = &(field_eq | ~cmp_en);
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= sec_tick && hit;
  end

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_alarm_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2,
  parameter int N_FIELDS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEC_W-1:0]  now_sec,
  input  logic [MIN_W-1:0]  now_min,
  input  logic [HOUR_W-1:0] now_hour,
  input  logic [DAY_W-1:0]  now_day,
  input  logic              sec_tick,
  output logic              alarm_irq
);

  localparam int FLAT_W = N_FIELDS * DATA_W;

  logic [FLAT_W-1:0]   alm_flat;
  logic [N_FIELDS-1:0] mask_bits;
  logic [N_FIELDS-1:0] cmp_en;
  rpt_mode_e           mode;

  alarm_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_FIELDS(N_FIELDS)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .alm_flat(alm_flat)
  );

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_mask
    assign mask_bits[i] = alm_flat[i*DATA_W + DATA_W - 1];
  end

  alarm_mode_decode #(.N_FIELDS(N_FIELDS)) u_mode (
    .mask_bits(mask_bits), .mode(mode), .cmp_en(cmp_en)
  );

  alarm_match #(.DATA_W(DATA_W), .N_FIELDS(N_FIELDS)) u_match (
    .clk(clk), .rst(rst), .alm_flat(alm_flat), .cmp_en(cmp_en),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_day(now_day), .sec_tick(sec_tick), .irq(alarm_irq)
  );

endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk
  import rtc_alarm_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [6:0] now_sec,
  input logic       sec_tick,
  input logic       alarm_irq,
  input logic [31:0] alm_flat
);

  logic [7:0] a_sec, a_hour, a_day;
  logic [6:0] sec_dec;
  logic [6:0] hour_dec;
  assign a_sec    = alm_flat[7:0];
  assign a_hour   = alm_flat[23:16];
  assign a_day    = alm_flat[31:24];
  assign sec_dec  = bcd_decode(wr_data[6:0]);
  assign hour_dec = bcd_decode({1'b0, wr_data[5:0]});

  AST_NO_IRQ_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
    !sec_tick |=> !alarm_irq); // R11

  AST_BAD_SEC_HELD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd0 && sec_dec > 7'd59) |=> $stable(a_sec)); // R2

  AST_BAD_HOUR_HELD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd2 && hour_dec > 7'd23) |=> $stable(a_hour)); // R3

  AST_DAY_ALWAYS_STORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd3) |=> a_day == $past(wr_data)); // R4

  AST_ALL_MASKED_FIRES: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !wr_en && alm_flat[7] && alm_flat[15] && alm_flat[23] && alm_flat[31])
    |=> alarm_irq); // R9

  AST_MONTH_SEC_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !alm_flat[7] && !alm_flat[15] && !alm_flat[23] && !alm_flat[31]
     && now_sec != a_sec[6:0]) |=> !alarm_irq); // R5

endmodule

bind rtc_alarm_unit rtc_alarm_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .now_sec(now_sec), .sec_tick(sec_tick), .alarm_irq(alarm_irq),
  .alm_flat(alm_flat)
);

// File: tb/rtc_alarm_unit_tb.sv
module rtc_alarm_unit_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [6:0] now_sec = '0;
  logic [6:0] now_min = '0;
  logic [5:0] now_hour = '0;
  logic [5:0] now_day = '0;
  logic       sec_tick = 1'b0;
  logic       alarm_irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rtc_alarm_unit u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour), .now_day(now_day),
    .sec_tick(sec_tick), .alarm_irq(alarm_irq)
  );

  task automatic check(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: alarm_irq=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input logic [7:0] s, input logic [7:0] m,
                      input logic [7:0] h, input logic [7:0] d);
    wr(2'd0, s); wr(2'd1, m); wr(2'd2, h); wr(2'd3, d);
  endtask

  // Present a time with the strobe, then sample one clock later
  task automatic tick_at(input logic [6:0] s, input logic [6:0] m,
                         input logic [5:0] h, input logic [5:0] d,
                         input logic exp, input string tag);
    @(negedge clk);
    now_sec = s; now_min = m; now_hour = h; now_day = d; sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    check(alarm_irq, exp, tag);
  endtask

  task automatic t_reset;
    check(alarm_irq, 1'b0, "R12 irq low after reset");
    tick_at(7'h00, 7'h00, 6'h00, 6'h00, 1'b1, "R12 cleared registers match zero time");
  endtask

  task automatic t_monthly;
    load(8'h30, 8'h45, 8'h12, 8'h15);
    tick_at(7'h30, 7'h45, 6'h12, 6'h15, 1'b1, "R5 R1 full match fires");
    tick_at(7'h30, 7'h45, 6'h12, 6'h16, 1'b0, "R5 day mismatch");
    tick_at(7'h31, 7'h45, 6'h12, 6'h15, 1'b0, "R5 second mismatch");
    tick_at(7'h30, 7'h44, 6'h12, 6'h15, 1'b0, "R5 minute mismatch");
  endtask

  task automatic t_pulse;
    @(negedge clk);
    now_sec = 7'h30; now_min = 7'h45; now_hour = 6'h12; now_day = 6'h15;
    @(negedge clk);
    check(alarm_irq, 1'b0, "R11 match without tick is quiet");
    tick_at(7'h30, 7'h45, 6'h12, 6'h15, 1'b1, "R11 tick fires");
    @(negedge clk);
    check(alarm_irq, 1'b0, "R11 pulse lasts one cycle");
  endtask

  task automatic t_ranges;
    wr(2'd0, 8'h60);
    wr(2'd1, 8'h7F);
    tick_at(7'h30, 7'h45, 6'h12, 6'h15, 1'b1, "R2 rejected sec/min writes keep old");
    wr(2'd0, 8'h59);
    tick_at(7'h59, 7'h45, 6'h12, 6'h15, 1'b1, "R2 59 accepted");
    wr(2'd2, 8'h24);
    tick_at(7'h59, 7'h45, 6'h12, 6'h15, 1'b1, "R3 hour 24 rejected");
    wr(2'd2, 8'h23);
    tick_at(7'h59, 7'h45, 6'h12, 6'h15, 1'b0, "R3 hour 23 replaces 12");
    tick_at(7'h59, 7'h45, 6'h23, 6'h15, 1'b1, "R3 hour 23 matches");
    wr(2'd3, 8'h31);
    tick_at(7'h59, 7'h45, 6'h23, 6'h31, 1'b1, "R4 day 31 stored");
  endtask

  task automatic t_daily;
    load(8'h10, 8'h20, 8'h08, 8'h80 | 8'h05);
    tick_at(7'h10, 7'h20, 6'h08, 6'h27, 1'b1, "R6 other day fires");
    tick_at(7'h10, 7'h20, 6'h09, 6'h05, 1'b0, "R6 hour mismatch");
  endtask

  task automatic t_hourly;
    wr(2'd2, 8'h88);
    tick_at(7'h10, 7'h20, 6'h17, 6'h02, 1'b1, "R7 other hour fires");
    tick_at(7'h10, 7'h21, 6'h08, 6'h05, 1'b0, "R7 minute mismatch");
  endtask

  task automatic t_minute;
    wr(2'd1, 8'hA0);
    tick_at(7'h10, 7'h55, 6'h03, 6'h11, 1'b1, "R8 other minute fires");
    tick_at(7'h11, 7'h20, 6'h08, 6'h05, 1'b0, "R8 second mismatch");
  endtask

  task automatic t_every;
    wr(2'd0, 8'h90);
    tick_at(7'h42, 7'h13, 6'h21, 6'h29, 1'b1, "R9 all masked fires");
    tick_at(7'h00, 7'h00, 6'h00, 6'h01, 1'b1, "R9 all masked fires again");
  endtask

  task automatic t_odd_mask;
    load(8'hB0, 8'h45, 8'h12, 8'h15);
    tick_at(7'h01, 7'h02, 6'h03, 6'h04, 1'b1, "R10 sec-only mask repeats every second");
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_monthly;
    t_pulse;
    t_ranges;
    t_daily;
    t_hourly;
    t_minute;
    t_every;
    t_odd_mask;
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule